// File: doc/BRIEF.md
# Hardware Stack Context Engine

This block owns the stack pointer of a small 8-bit processor and drives a byte-wide synchronous memory port. A processor core gives it a command code and a start strobe. The block then carries out a single-byte push or pull, or a fixed multi-byte sequence: saving or restoring a subroutine return address, or saving or restoring a whole interrupt frame. The stack grows toward lower addresses, and the pointer always names the next free byte. A push writes at the pointer and then moves it down. A pull moves the pointer up and then reads.

All register values that a push sequence needs are sampled in the cycle the command is accepted. The core may change its register inputs while the sequence runs. Bytes that come back from memory are collected into registered outputs for the program counter, the two index registers, the two accumulators and the condition codes. A one-cycle done pulse tells the core that the sequence has finished. The memory has one cycle of read latency: read data appears in the cycle after the read is presented.

Top module: `stack_ctx_engine`

## Requirements
- R1: While reset is held and after it is released, the pointer is 0x00FF. Memory write enable, read enable and done are low, and every restored register output is zero.
- R2: Push A (code 2) and push B (code 3) write the accumulator byte at the address held in the pointer, then lower the pointer by one.
- R3: Pull A (code 6) and pull B (code 7) raise the pointer by one and read the new pointer address. The byte read then appears on the matching accumulator output.
- R4: Call (code 10) writes the low byte of pc_in at the pointer, then the high byte at the pointer minus one. The pointer ends two lower than it started.
- R5: Return (code 11) reads the pointer plus one into the high byte of pc_out, then reads the pointer plus two into the low byte. The pointer ends two higher than it started.
- R6: Interrupt save (code 12) makes nine writes at descending addresses, in this order: PC low, PC high, Y low, Y high, X low, X high, A, B, CC. The values written are those present on the inputs in the cycle the command was accepted.
- R7: Interrupt return (code 13) makes nine reads at ascending addresses and fills CC, B, A, X high, X low, Y high, Y low, PC high and PC low, in that order. It restores a frame saved by R6 exactly.
- R8: Push X (4) and push Y (5) write the low byte and then the high byte. Pull X (8) and pull Y (9) read the high byte and then the low byte.
- R9: A sequence makes one memory access per cycle, starting in the cycle after acceptance. Done is high for exactly one cycle. For pushes, that cycle follows the last write. For pulls, it is the second cycle after the last read. For a pointer load, it is the cycle after acceptance. No access takes place in a done cycle.
- R10: A start that arrives while a sequence is in progress, before its done cycle, is ignored. It causes no extra access and does not change the running sequence.
- R11: Codes 0, 14 and 15 are ignored. They cause no access and no done pulse, and the pointer does not change.
- R12: The pointer wraps modulo 2^16 in both directions without any flag: a push at 0x0000 leaves 0xFFFF, and a pull from 0xFFFF reads address 0x0000.
- R13: Load pointer (code 1) copies sp_load into the pointer. The new value is visible on sp_out in the cycle after acceptance.
- R14: Write enable and read enable are never high together. During a write, mem_addr equals sp_out plus one. During a read, mem_addr equals sp_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, honoured only when idle |
| cmd | input | 4 | Command code |
| sp_load | input | 16 | New pointer value for the load command |
| pc_in | input | 16 | Program counter / return address to save |
| x_in | input | 16 | Index register X to save |
| y_in | input | 16 | Index register Y to save |
| a_in | input | 8 | Accumulator A to save |
| b_in | input | 8 | Accumulator B to save |
| cc_in | input | 8 | Condition codes to save |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| sp_out | output | 16 | Current stack pointer |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 16 | Restored index X |
| y_out | output | 16 | Restored index Y |
| a_out | output | 8 | Restored accumulator A |
| b_out | output | 8 | Restored accumulator B |
| cc_out | output | 8 | Restored condition codes |
| done | output | 1 | One-cycle completion pulse |

## Verification
Call the clock edge that accepts the command edge 0. Access k of an n-byte sequence (k counted from 0) is on the port in cycle k+1. A push finishes with done in cycle n+1. A pull finishes with done in cycle n+2, together with its last restored byte, because the memory read takes one cycle and the capture register takes another. A pointer load raises done in cycle 1. The bench computes these cycle numbers from the command length and samples every port at the falling edge of each cycle from 1 to the done cycle. It compares each sample with a queue of expected addresses and bytes, then checks once more in the following cycle that done has fallen and that the pointer and the restored outputs match its model.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int CMD_W       = 4;
  localparam int FRAME_BYTES = 9;

  typedef enum logic [CMD_W-1:0] {
    OP_NONE  = 4'd0,
    OP_SETSP = 4'd1,
    OP_PSHA  = 4'd2,
    OP_PSHB  = 4'd3,
    OP_PSHX  = 4'd4,
    OP_PSHY  = 4'd5,
    OP_PULA  = 4'd6,
    OP_PULB  = 4'd7,
    OP_PULX  = 4'd8,
    OP_PULY  = 4'd9,
    OP_CALL  = 4'd10,
    OP_RETN  = 4'd11,
    OP_IRQ   = 4'd12,
    OP_IRET  = 4'd13
  } stk_op_e;

  // Frame slot numbers double as the interrupt push order.
  typedef enum logic [3:0] {
    F_PCL = 4'd0,
    F_PCH = 4'd1,
    F_YL  = 4'd2,
    F_YH  = 4'd3,
    F_XL  = 4'd4,
    F_XH  = 4'd5,
    F_A   = 4'd6,
    F_B   = 4'd7,
    F_CC  = 4'd8
  } fld_e;

  function automatic logic op_legal(logic [CMD_W-1:0] c);
    return (c >= 4'd1) && (c <= 4'd13);
  endfunction

  function automatic logic op_is_pull(stk_op_e op);
    case (op)
      OP_PULA, OP_PULB, OP_PULX, OP_PULY, OP_RETN, OP_IRET: return 1'b1;
      default:                                              return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] op_len(stk_op_e op);
    case (op)
      OP_PSHA, OP_PSHB, OP_PULA, OP_PULB:                   return 4'd1;
      OP_PSHX, OP_PSHY, OP_PULX, OP_PULY, OP_CALL, OP_RETN: return 4'd2;
      OP_IRQ, OP_IRET:                                      return 4'd9;
      default:                                              return 4'd0;
    endcase
  endfunction

  // First frame slot of the contiguous run of slots that a command moves.
  function automatic logic [3:0] op_base(stk_op_e op);
    case (op)
      OP_PSHA, OP_PULA: return 4'd6;
      OP_PSHB, OP_PULB: return 4'd7;
      OP_PSHX, OP_PULX: return 4'd4;
      OP_PSHY, OP_PULY: return 4'd2;
      default:          return 4'd0;
    endcase
  endfunction

  // Pushes walk the slots upward; pulls walk the same slots downward.
  function automatic fld_e op_field(stk_op_e op, logic [3:0] idx);
    logic [3:0] k;
    k = op_is_pull(op) ? (op_len(op) - 4'd1 - idx) : idx;
    return fld_e'(op_base(op) + k);
  endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd,
  input  logic             finish,
  output logic             accept,
  output logic             load_sp,
  output logic             step_vld,
  output logic             step_pull,
  output fld_e             step_fld,
  output logic             step_last
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_TAIL} st_e;

  st_e        st;
  stk_op_e    op_q;
  logic [3:0] idx_q;

  stk_op_e    op_live;
  stk_op_e    op_cur;
  logic [3:0] idx_cur;
  logic       idle;

  always_comb begin
    op_live   = stk_op_e'(cmd);
    idle      = (st == S_IDLE);
    accept    = idle && start && op_legal(cmd) && (op_live != OP_SETSP);
    load_sp   = idle && start && (op_live == OP_SETSP);
    op_cur    = accept ? op_live : op_q;
    idx_cur   = accept ? 4'd0 : idx_q;
    step_vld  = accept || (st == S_ISSUE);
    step_pull = op_is_pull(op_cur);
    step_fld  = op_field(op_cur, idx_cur);
    step_last = (idx_cur == (op_len(op_cur) - 4'd1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      op_q  <= OP_NONE;
      idx_q <= 4'd0;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            op_q  <= op_live;
            idx_q <= 4'd1;
            st    <= step_last ? S_TAIL : S_ISSUE;
          end
        end
        S_ISSUE: begin
          idx_q <= idx_q + 4'd1;
          if (step_last) st <= S_TAIL;
        end
        S_TAIL: begin
          if (finish) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Once the last byte is issued, a fresh start must not inject more steps.
  assert_tail_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (st == S_TAIL) |-> !step_vld);

  // A start during a running sequence must not be taken.
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && start) |=> (op_q == $past(op_q)));

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = 'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_vld,
  input  logic              step_pull,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [ADDR_W-1:0] sp_inc;
  logic [ADDR_W-1:0] sp_dec;

  always_comb begin
    sp_inc   = sp + ADDR_W'(1);
    sp_dec   = sp - ADDR_W'(1);
    acc_addr = step_pull ? sp_inc : sp;
  end

  always_ff @(posedge clk) begin
    if (rst)           sp <= SP_INIT;
    else if (load)     sp <= load_val;
    else if (step_vld) sp <= step_pull ? sp_inc : sp_dec;
  end

  // Outside a load the pointer moves by at most one, wrapping freely.
  assert_sp_step_R12: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((sp == $past(sp)) ||
               (sp == ADDR_W'($past(sp) + ADDR_W'(1))) ||
               (sp == ADDR_W'($past(sp) - ADDR_W'(1)))));

endmodule

// File: rtl/stk_snap.sv
module stk_snap
  import stk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [2*DATA_W-1:0] x_in,
  input  logic [2*DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [DATA_W-1:0] cc_in,
  input  fld_e              sel,
  output logic [DATA_W-1:0] byte_out
);

  logic [DATA_W-1:0] live [FRAME_BYTES];
  logic [DATA_W-1:0] held [FRAME_BYTES];
  logic [DATA_W-1:0] src  [FRAME_BYTES];

  always_comb begin
    live[F_PCL] = pc_in[DATA_W-1:0];
    live[F_PCH] = pc_in[2*DATA_W-1:DATA_W];
    live[F_YL]  = y_in[DATA_W-1:0];
    live[F_YH]  = y_in[2*DATA_W-1:DATA_W];
    live[F_XL]  = x_in[DATA_W-1:0];
    live[F_XH]  = x_in[2*DATA_W-1:DATA_W];
    live[F_A]   = a_in;
    live[F_B]   = b_in;
    live[F_CC]  = cc_in;
  end

  // Snapshot taken on acceptance; the first byte comes straight from inputs.
  always_ff @(posedge clk) begin
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (rst)         held[i] <= '0;
      else if (accept) held[i] <= live[i];
    end
  end

  always_comb begin
    byte_out = '0;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      src[i] = accept ? live[i] : held[i];
      if (4'(i) == sel) byte_out = src[i];
    end
  end

endmodule

// File: rtl/stk_xfer.sv
module stk_xfer
  import stk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_vld,
  input  logic                step_pull,
  input  fld_e                step_fld,
  input  logic                step_last,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [DATA_W-1:0]   wbyte,
  input  logic                load_sp,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic                finish,
  output logic                done,
  output logic [2*DATA_W-1:0] pc_out,
  output logic [2*DATA_W-1:0] x_out,
  output logic [2*DATA_W-1:0] y_out,
  output logic [DATA_W-1:0]   a_out,
  output logic [DATA_W-1:0]   b_out,
  output logic [DATA_W-1:0]   cc_out
);

  logic              last_q;
  fld_e              fld_q;
  logic              rt_vld;
  logic              rt_last;
  fld_e              rt_fld;
  logic [DATA_W-1:0] rest [FRAME_BYTES];

  // Last write on the port now, or last read byte arriving now.
  assign finish = (mem_we && last_q) || (rt_vld && rt_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      last_q    <= 1'b0;
      fld_q     <= F_PCL;
      rt_vld    <= 1'b0;
      rt_last   <= 1'b0;
      rt_fld    <= F_PCL;
      done      <= 1'b0;
    end else begin
      mem_we <= step_vld && !step_pull;
      mem_re <= step_vld && step_pull;
      if (step_vld) begin
        mem_addr <= acc_addr;
        fld_q    <= step_fld;
        last_q   <= step_last;
      end
      if (step_vld && !step_pull) mem_wdata <= wbyte;
      rt_vld  <= mem_re;
      rt_last <= mem_re && last_q;
      rt_fld  <= fld_q;
      done    <= finish || load_sp;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (rst)                             rest[i] <= '0;
      else if (rt_vld && (4'(i) == rt_fld)) rest[i] <= mem_rdata;
    end
  end

  always_comb begin
    pc_out = {rest[F_PCH], rest[F_PCL]};
    y_out  = {rest[F_YH],  rest[F_YL]};
    x_out  = {rest[F_XH],  rest[F_XL]};
    a_out  = rest[F_A];
    b_out  = rest[F_B];
    cc_out = rest[F_CC];
  end

  assert_rw_excl_R14: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_re));

endmodule

// File: rtl/stack_ctx_engine.sv
module stack_ctx_engine
  import stk_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] SP_INIT = 'h00FF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CMD_W-1:0]    cmd,
  input  logic [ADDR_W-1:0]   sp_load,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [2*DATA_W-1:0] x_in,
  input  logic [2*DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   b_in,
  input  logic [DATA_W-1:0]   cc_in,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic [ADDR_W-1:0]   sp_out,
  output logic [2*DATA_W-1:0] pc_out,
  output logic [2*DATA_W-1:0] x_out,
  output logic [2*DATA_W-1:0] y_out,
  output logic [DATA_W-1:0]   a_out,
  output logic [DATA_W-1:0]   b_out,
  output logic [DATA_W-1:0]   cc_out,
  output logic                done
);

  logic              accept;
  logic              load_sp;
  logic              step_vld;
  logic              step_pull;
  fld_e              step_fld;
  logic              step_last;
  logic              finish;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] wbyte;

  stk_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (cmd),
    .finish    (finish),
    .accept    (accept),
    .load_sp   (load_sp),
    .step_vld  (step_vld),
    .step_pull (step_pull),
    .step_fld  (step_fld),
    .step_last (step_last)
  );

  stk_ptr #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (load_sp),
    .load_val  (sp_load),
    .step_vld  (step_vld),
    .step_pull (step_pull),
    .sp        (sp_out),
    .acc_addr  (acc_addr)
  );

  stk_snap #(.DATA_W(DATA_W)) u_snap (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .pc_in    (pc_in),
    .x_in     (x_in),
    .y_in     (y_in),
    .a_in     (a_in),
    .b_in     (b_in),
    .cc_in    (cc_in),
    .sel      (step_fld),
    .byte_out (wbyte)
  );

  stk_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .step_vld  (step_vld),
    .step_pull (step_pull),
    .step_fld  (step_fld),
    .step_last (step_last),
    .acc_addr  (acc_addr),
    .wbyte     (wbyte),
    .load_sp   (load_sp),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .finish    (finish),
    .done      (done),
    .pc_out    (pc_out),
    .x_out     (x_out),
    .y_out     (y_out),
    .a_out     (a_out),
    .b_out     (b_out),
    .cc_out    (cc_out)
  );

  // Write happens at the old pointer, which has already moved down.
  assert_push_addr_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == ADDR_W'(sp_out + ADDR_W'(1))));

  // Read happens at the pointer after it has moved up.
  assert_pull_addr_R3: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr == sp_out));

endmodule

// File: tb/stack_ctx_engine_test.sv
module stack_ctx_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [15:0] sp_load = 16'h0;
  logic [15:0] pc_in = 16'h0, x_in = 16'h0, y_in = 16'h0;
  logic [7:0]  a_in = 8'h0, b_in = 8'h0, cc_in = 8'h0;
  logic [7:0]  mem_rdata = 8'h0;
  logic [15:0] mem_addr, sp_out, pc_out, x_out, y_out;
  logic [7:0]  mem_wdata, a_out, b_out, cc_out;
  logic        mem_we, mem_re, done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // Reference model state
  logic [15:0] m_sp = 16'h00FF;
  logic [7:0]  m_out [9];
  logic [7:0]  mmem [logic [15:0]];
  logic [7:0]  ram  [logic [15:0]];

  stack_ctx_engine uut (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .sp_load(sp_load),
    .pc_in(pc_in), .x_in(x_in), .y_in(y_in), .a_in(a_in), .b_in(b_in),
    .cc_in(cc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .sp_out(sp_out),
    .pc_out(pc_out), .x_out(x_out), .y_out(y_out), .a_out(a_out),
    .b_out(b_out), .cc_out(cc_out), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Synchronous byte memory with one cycle of read latency
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= ram.exists(mem_addr) ? ram[mem_addr] : 8'h00;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mrd(input logic [15:0] a);
    return mmem.exists(a) ? mmem[a] : 8'h00;
  endfunction

  task automatic chk_state(input string req);
    chk(req, "sp_out", {16'h0, sp_out}, {16'h0, m_sp});
    chk(req, "pc_out", {16'h0, pc_out}, {16'h0, m_out[1], m_out[0]});
    chk(req, "y_out",  {16'h0, y_out},  {16'h0, m_out[3], m_out[2]});
    chk(req, "x_out",  {16'h0, x_out},  {16'h0, m_out[5], m_out[4]});
    chk(req, "a_out",  {24'h0, a_out},  {24'h0, m_out[6]});
    chk(req, "b_out",  {24'h0, b_out},  {24'h0, m_out[7]});
    chk(req, "cc_out", {24'h0, cc_out}, {24'h0, m_out[8]});
  endtask

  // Slots: 0 PCL 1 PCH 2 YL 3 YH 4 XL 5 XH 6 A 7 B 8 CC
  task automatic do_op(input logic [3:0] op, input string req, input bit poke);
    int          fl[$];
    logic [15:0] ea[$];
    logic [7:0]  ed[$];
    logic [7:0]  live [9];
    bit          pull;
    int          n, dn;
    string       rq;
    logic [15:0] a;
    case (op)
      4'd2, 4'd6:   fl = '{6};
      4'd3, 4'd7:   fl = '{7};
      4'd4, 4'd8:   fl = '{4, 5};
      4'd5, 4'd9:   fl = '{2, 3};
      4'd10, 4'd11: fl = '{0, 1};
      default:      fl = '{0, 1, 2, 3, 4, 5, 6, 7, 8};
    endcase
    pull = (op >= 4'd6 && op <= 4'd9) || op == 4'd11 || op == 4'd13;
    if (pull) fl.reverse();
    live[0] = pc_in[7:0]; live[1] = pc_in[15:8];
    live[2] = y_in[7:0];  live[3] = y_in[15:8];
    live[4] = x_in[7:0];  live[5] = x_in[15:8];
    live[6] = a_in; live[7] = b_in; live[8] = cc_in;
    n = fl.size();
    for (int i = 0; i < n; i++) begin
      if (pull) begin
        m_sp = m_sp + 16'd1;
        a = m_sp;
        ea.push_back(a);
        ed.push_back(8'h00);
        m_out[fl[i]] = mrd(a);
      end else begin
        a = m_sp;
        ea.push_back(a);
        ed.push_back(live[fl[i]]);
        mmem[a] = live[fl[i]];
        m_sp = m_sp - 16'd1;
      end
    end
    dn = pull ? n + 2 : n + 1;
    rq = poke ? "R10" : req;
    start = 1'b1;
    cmd = op;
    @(negedge clk);
    start = 1'b0;
    if (op == 4'd12) begin  // scramble inputs after acceptance
      pc_in = ~pc_in; x_in = ~x_in; y_in = ~y_in;
      a_in = ~a_in; b_in = ~b_in; cc_in = ~cc_in;
    end
    for (int c = 1; c <= dn; c++) begin
      if (c <= n) begin
        chk(rq, "we", {31'h0, mem_we}, {31'h0, !pull});
        chk(rq, "re", {31'h0, mem_re}, {31'h0, pull});
        chk(rq, "addr", {16'h0, mem_addr}, {16'h0, ea[c-1]});
        if (!pull) chk(rq, "wdata", {24'h0, mem_wdata}, {24'h0, ed[c-1]});
      end else begin
        chk("R9", "idle we", {31'h0, mem_we}, 32'h0);
        chk("R9", "idle re", {31'h0, mem_re}, 32'h0);
      end
      chk("R9", "done", {31'h0, done}, {31'h0, (c == dn)});
      if (poke && c == 2) begin
        start = 1'b1;
        cmd = 4'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk("R9", "done fell", {31'h0, done}, 32'h0);
    chk_state(req);
  endtask

  task automatic do_load(input logic [15:0] v);
    start = 1'b1;
    cmd = 4'd1;
    sp_load = v;
    @(negedge clk);
    start = 1'b0;
    m_sp = v;
    chk("R13", "sp_out", {16'h0, sp_out}, {16'h0, v});
    chk("R9", "load done", {31'h0, done}, 32'h1);
    @(negedge clk);
    chk("R9", "load done fell", {31'h0, done}, 32'h0);
  endtask

  task automatic do_ignore(input logic [3:0] code);
    start = 1'b1;
    cmd = code;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R11", "we", {31'h0, mem_we}, 32'h0);
      chk("R11", "re", {31'h0, mem_re}, 32'h0);
      chk("R11", "done", {31'h0, done}, 32'h0);
      chk("R11", "sp", {16'h0, sp_out}, {16'h0, m_sp});
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 9; i++) m_out[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs while reset held
    chk("R1", "sp in reset", {16'h0, sp_out}, 32'h00FF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "we", {31'h0, mem_we}, 32'h0);
    chk("R1", "re", {31'h0, mem_re}, 32'h0);
    chk("R1", "done", {31'h0, done}, 32'h0);
    chk_state("R1");

    // R2 / R3: single-byte pushes and pulls
    a_in = 8'h3C; b_in = 8'hA5;
    do_op(4'd2, "R2", 1'b0);
    do_op(4'd3, "R2", 1'b0);
    do_op(4'd6, "R3", 1'b0);
    do_op(4'd7, "R3", 1'b0);

    // R13: load pointer
    do_load(16'h2000);

    // R8: 16-bit registers
    x_in = 16'h1234; y_in = 16'hBEEF;
    do_op(4'd4, "R8", 1'b0);
    do_op(4'd5, "R8", 1'b0);
    do_op(4'd8, "R8", 1'b0);
    do_op(4'd9, "R8", 1'b0);

    // R4 / R5: call and return
    pc_in = 16'h4567;
    do_op(4'd10, "R4", 1'b0);
    do_op(4'd11, "R5", 1'b0);

    // R6 / R7 / R10: interrupt frame with a start poked mid-sequence
    pc_in = 16'hC0DE; x_in = 16'h5A69; y_in = 16'h0F1E;
    a_in = 8'h11; b_in = 8'h22; cc_in = 8'hD4;
    do_op(4'd12, "R6", 1'b1);
    do_op(4'd13, "R7", 1'b0);
    do_op(4'd12, "R6", 1'b0);
    do_op(4'd13, "R7", 1'b0);

    // R11: undefined codes
    do_ignore(4'd0);
    do_ignore(4'd14);
    do_ignore(4'd15);

    // R12: wrap in both directions
    do_load(16'h0000);
    a_in = 8'h77;
    do_op(4'd2, "R12", 1'b0);
    chk("R12", "sp after wrap", {16'h0, sp_out}, 32'hFFFF);
    do_op(4'd6, "R12", 1'b0);
    pc_in = 16'h9ABC;
    do_op(4'd10, "R12", 1'b0);
    do_op(4'd11, "R12", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule